// File: doc/BRIEF.md
# ECC Error Capture Register

This block sits beside the ECC checker of a memory controller whose data path is 72 bits wide: 64 data bits and 8 check bits. Each read completion comes with a checker verdict. The verdict has a valid strobe, a corrected-error flag (single bit), an uncorrectable-error flag (multi bit), an 8-bit syndrome and the 32-bit physical address of the read.

The block keeps the first error it sees in one 32-bit status/control word. Software reads and writes that word through a plain register port. While an error is held, the address, syndrome and error type stay frozen until software clears both status flags. The block raises a level NMI request for a held corrected error and a level system-error request for a held uncorrectable error. Each request has its own enable bit. After every corrected read it also pulses a scrub request, so that the corrected word is written back to memory, unless software has turned scrubbing off.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset, every bit of the register reads 0. Scrubbing is therefore enabled, and `nmi_req`, `serr_req` and `scrub_req` are all low.
- R2: The register is armed when bits 1 and 0 both read 0. A valid verdict that arrives while armed, with only the single-bit flag set, does three things on the next clock: it sets bit 0, loads bits 30:12 with address bits 31:13, and loads bits 11:4 with the syndrome.
- R3: A valid verdict that arrives while armed with the multi-bit flag set sets bit 1 instead. This holds even when the single-bit flag is set in the same cycle; in that case bit 0 stays 0. The address and syndrome are loaded as in R2.
- R4: While bit 0 or bit 1 is set, further error verdicts change no status bit, no address bit and no syndrome bit. Only the first error type is kept.
- R5: Bits 1 and 0 are write-1-to-clear: a write with a 1 in either position clears that status bit, and a 0 leaves it unchanged. Writes to bits 30:4 are ignored.
- R6: Capture resumes only when both status bits read 0. A write of 1 to the status bit that is not set leaves the held error in place and keeps new errors out.
- R7: Bit 31 (scrub disable), bit 3 (system-error enable) and bit 2 (NMI enable) are read/write. They take the written value on the clock after a write.
- R8: `nmi_req` is a level equal to bit 0 AND bit 2.
- R9: `serr_req` is a level equal to bit 1 AND bit 3.
- R10: One cycle after a valid verdict with the single-bit flag set and the multi-bit flag clear, `scrub_req` is high for one cycle if bit 31 is 0. A verdict with the multi-bit flag set never requests a scrub. This happens whatever the status bits hold.
- R11: A verdict with the valid strobe low has no effect on the register or on `scrub_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_valid | input | 1 | Checker verdict valid for this read completion |
| chk_sbe | input | 1 | Correctable single-bit error seen |
| chk_mbe | input | 1 | Uncorrectable multi-bit error seen |
| chk_syndrome | input | 8 | ECC syndrome of this read |
| chk_addr | input | 32 | Physical address of this read |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register contents |
| nmi_req | output | 1 | Level NMI request for a held corrected error |
| serr_req | output | 1 | Level system-error request for a held uncorrectable error |
| scrub_req | output | 1 | One-cycle write-back request after a corrected read |

## Verification
Every piece of state this block holds can be read back in `reg_rdata` on the clock edge after it changes. A wrong capture, a freeze that fails, or a clear that goes wrong therefore shows up one cycle after the verdict or write that caused it. A lost arm state is the exception: it stays hidden until the next error verdict, and then shows as a status word that does not change. For that reason the bench sweeps every starting state (armed, holding a corrected error, holding an uncorrectable error) against every flag combination, with the valid strobe both high and low. Request outputs that are wrong follow from the status and enable bits on the same cycle, and a wrong scrub pulse appears exactly one cycle after its verdict.

// File: rtl/ecc_cap_pkg.sv
// Package: bit layout of the ECC capture word and shared types.
// Assumes one 32-bit word. Bit positions are fixed because software decodes them.
package ecc_cap_pkg;
    localparam int REG_W       = 32;
    localparam int DATA_W      = 64;
    localparam int CHECK_W     = 8;
    localparam int LANE_W      = DATA_W + CHECK_W;
    localparam int SCRUB_DIS_B = 31;
    localparam int LOC_HI      = 30;
    localparam int LOC_LO      = 12;
    localparam int SYN_HI      = 11;
    localparam int SYN_LO      = 4;
    localparam int SERR_EN_B   = 3;
    localparam int NMI_EN_B    = 2;
    localparam int MBE_B       = 1;
    localparam int SBE_B       = 0;
    localparam int LOC_W       = LOC_HI - LOC_LO + 1;
    localparam int SYN_W       = SYN_HI - SYN_LO + 1;

    typedef struct packed {
        logic mbe;
        logic sbe;
    } err_flags_t;

    typedef struct packed {
        logic scrub_dis;
        logic serr_en;
        logic nmi_en;
    } ctrl_bits_t;
endpackage

// File: rtl/ecc_cap_log.sv
// Module: first-error log. Holds the error type, the coarse address and the syndrome.
// Assumes: a multi-bit error outranks a single-bit error seen in the same cycle.
// If the log is armed when an error arrives, the capture wins over a clear in that cycle.
module ecc_cap_log
    import ecc_cap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int KEEP_W = LOC_W,
    parameter int SYNW   = SYN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic              ev_sbe,
    input  logic              ev_mbe,
    input  logic [SYNW-1:0]   ev_syn,
    input  logic [ADDR_W-1:0] ev_addr,
    input  err_flags_t        clr_mask,
    output err_flags_t        flags,
    output logic [KEEP_W-1:0] loc,
    output logic [SYNW-1:0]   syn
);
    logic armed;
    logic take;

    // Decide whether this cycle's verdict is logged.
    always_comb begin
        armed = !flags.mbe && !flags.sbe;
        take  = armed && ev_valid && (ev_sbe || ev_mbe);
    end

    // Status flags: set on the first error, otherwise cleared bit by bit by write-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (take) begin
            flags.mbe <= ev_mbe;
            flags.sbe <= !ev_mbe;
        end else begin
            flags <= flags & ~clr_mask;
        end
    end

    // Location and syndrome: loaded only when the error is logged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc <= '0;
            syn <= '0;
        end else if (take) begin
            loc <= ev_addr[ADDR_W-1 -: KEEP_W];
            syn <= ev_syn;
        end
    end
endmodule

// File: rtl/ecc_cap_ctrl.sv
// Module: software control bits (scrub disable and the two request enables).
// Assumes: every write loads all three bits at once.
module ecc_cap_ctrl
    import ecc_cap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output ctrl_bits_t       ctrl
);
    // Load the control bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_en) begin
            ctrl.scrub_dis <= wdata[SCRUB_DIS_B];
            ctrl.serr_en   <= wdata[SERR_EN_B];
            ctrl.nmi_en    <= wdata[NMI_EN_B];
        end
    end
endmodule

// File: rtl/ecc_cap_signal.sv
// Module: request outputs. The interrupt requests are levels; the scrub request is a one-cycle pulse.
// Assumes: a corrected read is a valid verdict with the single-bit flag set and the multi-bit flag clear.
module ecc_cap_signal
    import ecc_cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  err_flags_t flags,
    input  ctrl_bits_t ctrl,
    input  logic       ev_valid,
    input  logic       ev_sbe,
    input  logic       ev_mbe,
    output logic       nmi_req,
    output logic       serr_req,
    output logic       scrub_req
);
    // Gate each held error flag with its enable.
    always_comb begin
        nmi_req  = flags.sbe && ctrl.nmi_en;
        serr_req = flags.mbe && ctrl.serr_en;
    end

    // Request a write-back one cycle after each corrected read.
    always_ff @(posedge clk) begin
        if (!rst_n) scrub_req <= 1'b0;
        else        scrub_req <= ev_valid && ev_sbe && !ev_mbe && !ctrl.scrub_dis;
    end
endmodule

// File: rtl/ecc_err_capture.sv
// Module: ECC first-error capture register (top).
// Assumes: a single register word with no address decode, and rdata that reflects the registers directly.
module ecc_err_capture
    import ecc_cap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_valid,
    input  logic              chk_sbe,
    input  logic              chk_mbe,
    input  logic [SYN_W-1:0]  chk_syndrome,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              nmi_req,
    output logic              serr_req,
    output logic              scrub_req
);
    err_flags_t       flags;
    err_flags_t       clr_mask;
    ctrl_bits_t       ctrl;
    logic [LOC_W-1:0] loc;
    logic [SYN_W-1:0] syn;
    logic             unused_bits;

    // Turn a register write into write-1-to-clear strobes for the status bits.
    always_comb begin
        clr_mask.mbe = reg_wr && reg_wdata[MBE_B];
        clr_mask.sbe = reg_wr && reg_wdata[SBE_B];
        unused_bits  = ^{reg_wdata[LOC_HI:SYN_LO], chk_addr[ADDR_W-LOC_W-1:0]};
    end

    ecc_cap_log #(.ADDR_W(ADDR_W), .KEEP_W(LOC_W), .SYNW(SYN_W)) u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_valid (chk_valid),
        .ev_sbe   (chk_sbe),
        .ev_mbe   (chk_mbe),
        .ev_syn   (chk_syndrome),
        .ev_addr  (chk_addr),
        .clr_mask (clr_mask),
        .flags    (flags),
        .loc      (loc),
        .syn      (syn)
    );

    ecc_cap_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .wdata (reg_wdata),
        .ctrl  (ctrl)
    );

    ecc_cap_signal u_sig (
        .clk       (clk),
        .rst_n     (rst_n),
        .flags     (flags),
        .ctrl      (ctrl),
        .ev_valid  (chk_valid),
        .ev_sbe    (chk_sbe),
        .ev_mbe    (chk_mbe),
        .nmi_req   (nmi_req),
        .serr_req  (serr_req),
        .scrub_req (scrub_req)
    );

    // Assemble the read word in its fixed bit layout.
    always_comb begin
        reg_rdata                  = '0;
        reg_rdata[SCRUB_DIS_B]     = ctrl.scrub_dis;
        reg_rdata[LOC_HI:LOC_LO]   = loc;
        reg_rdata[SYN_HI:SYN_LO]   = syn;
        reg_rdata[SERR_EN_B]       = ctrl.serr_en;
        reg_rdata[NMI_EN_B]        = ctrl.nmi_en;
        reg_rdata[MBE_B]           = flags.mbe;
        reg_rdata[SBE_B]           = flags.sbe;
    end
endmodule

// File: rtl/ecc_err_capture_chk.sv
// Module: assertion checker bound to ecc_err_capture. It watches ports only.
module ecc_err_capture_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        chk_valid,
    input logic        chk_sbe,
    input logic        chk_mbe,
    input logic        reg_wr,
    input logic [31:0] reg_rdata,
    input logic        nmi_req,
    input logic        serr_req,
    input logic        scrub_req
);
    // R4
    first_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rdata[1] && reg_rdata[0]));

    // R4
    frozen_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[1] || reg_rdata[0]) |=> $stable(reg_rdata[30:4]));

    // R3
    mbe_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[1:0] == 2'b00 && chk_valid && chk_mbe) |=> (reg_rdata[1] && !reg_rdata[0]));

    // R8
    nmi_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req == (reg_rdata[0] && reg_rdata[2]));

    // R9
    serr_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_req == (reg_rdata[1] && reg_rdata[3]));

    // R10
    scrub_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_sbe && !chk_mbe && !reg_rdata[31]) |=> scrub_req);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_valid && !reg_wr) |=> ($stable(reg_rdata) && !scrub_req));
endmodule

bind ecc_err_capture ecc_err_capture_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_valid (chk_valid),
    .chk_sbe   (chk_sbe),
    .chk_mbe   (chk_mbe),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .nmi_req   (nmi_req),
    .serr_req  (serr_req),
    .scrub_req (scrub_req)
);

// File: tb/ecc_err_capture_test.sv
// Bench: sweeps start state x verdict flags x valid, then the enables, scrub control and write masks.
module ecc_err_capture_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_valid = 1'b0;
    logic        chk_sbe = 1'b0;
    logic        chk_mbe = 1'b0;
    logic [7:0]  chk_syndrome = '0;
    logic [31:0] chk_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        nmi_req, serr_req, scrub_req;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_reg = '0;
    logic        m_scrub = 1'b0;

    always #10 clk = ~clk;

    ecc_err_capture uut (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_sbe(chk_sbe),
        .chk_mbe(chk_mbe), .chk_syndrome(chk_syndrome), .chk_addr(chk_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .nmi_req(nmi_req), .serr_req(serr_req), .scrub_req(scrub_req)
    );

    task automatic expect_eq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        expect_eq(req, "rdata", reg_rdata, m_reg);
        expect_eq(req, "nmi_req", {31'd0, nmi_req}, {31'd0, m_reg[0] & m_reg[2]});
        expect_eq(req, "serr_req", {31'd0, serr_req}, {31'd0, m_reg[1] & m_reg[3]});
        expect_eq(req, "scrub_req", {31'd0, scrub_req}, {31'd0, m_scrub});
    endtask

    // Present one verdict for one cycle, update the model, then check at the following falling edge.
    task automatic verdict(input logic v, input logic s, input logic m,
                           input logic [7:0] syn, input logic [31:0] addr, input string req);
        @(negedge clk);
        chk_valid = v; chk_sbe = s; chk_mbe = m; chk_syndrome = syn; chk_addr = addr;
        m_scrub = v && s && !m && !m_reg[31];
        if (v && (s || m) && m_reg[1:0] == 2'b00) begin
            m_reg[1:0]   = m ? 2'b10 : 2'b01;
            m_reg[30:12] = addr[31:13];
            m_reg[11:4]  = syn;
        end
        @(negedge clk);
        chk_valid = 1'b0; chk_sbe = 1'b0; chk_mbe = 1'b0;
        check_all(req);
    endtask

    task automatic write_reg(input logic [31:0] d, input string req);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        m_reg[31]   = d[31];
        m_reg[3:2]  = d[3:2];
        m_reg[1:0]  = m_reg[1:0] & ~d[1:0];
        m_scrub     = 1'b0;
        @(negedge clk);
        reg_wr = 1'b0;
        check_all(req);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2 R3 R4 R11: start state x flags x valid
        for (int st = 0; st < 3; st++) begin
            for (int fl = 0; fl < 4; fl++) begin
                for (int v = 0; v < 2; v++) begin
                    automatic logic [31:0] a = 32'h9E37_79B9 * (st * 8 + fl * 2 + v + 1);
                    automatic logic [7:0]  sy = 8'(37 * (st * 8 + fl * 2 + v) + 5);
                    automatic string tag = (v == 0) ? "R11" : (st != 0) ? "R4" : fl[1] ? "R3" : "R2";
                    write_reg({m_reg[31], 27'd0, m_reg[3:2], 2'b11}, "R5");
                    if (st == 1) verdict(1'b1, 1'b1, 1'b0, 8'hA5, 32'hFFFF_E000, "R2");
                    if (st == 2) verdict(1'b1, 1'b0, 1'b1, 8'h3C, 32'h0000_2000, "R3");
                    verdict(v[0], fl[0], fl[1], sy, a, tag);
                end
            end
        end

        // R8 R9: every enable pair against each held error type
        for (int en = 0; en < 4; en++) begin
            for (int ty = 0; ty < 2; ty++) begin
                write_reg({30'd0, 2'b11} | (32'(en) << 2), "R7");
                verdict(1'b1, ty == 0, ty == 1, 8'(en), 32'h1234_5678 + 32'(en), ty == 0 ? "R8" : "R9");
            end
        end

        // R10: scrub disable x flags, with the log both armed and full
        for (int dis = 0; dis < 2; dis++) begin
            for (int fl = 0; fl < 4; fl++) begin
                write_reg({dis[0], 29'd0, 2'b11}, "R7");
                verdict(1'b1, fl[0], fl[1], 8'h11, 32'h8000_0000, "R10");
                verdict(1'b1, fl[0], fl[1], 8'h22, 32'h4000_0000, "R10");
            end
        end

        // R5 R6: only the held bit clears; a write to the other bit or to read-only bits does nothing
        write_reg(32'h0000_0003, "R5");
        verdict(1'b1, 1'b1, 1'b0, 8'h77, 32'hDEAD_BEEF, "R2");
        write_reg(32'h7FFF_FFF2, "R6");
        write_reg(32'h0000_0000, "R5");
        verdict(1'b1, 1'b0, 1'b1, 8'h99, 32'h0BAD_F00D, "R6");
        write_reg(32'h0000_0001, "R6");
        verdict(1'b1, 1'b0, 1'b1, 8'h99, 32'h0BAD_F00D, "R6");
        write_reg(32'h8000_000C, "R7");
        write_reg(32'h0000_0002, "R5");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule